// File: doc/BRIEF.md
# Ping-Pong Receive Byte Buffer with Dual-Width CPU Read Port

This block stores received bytes between a serial signaling controller and a microprocessor read port. The storage is split into two equal halves. The controller fills one half while the processor drains the other. The two halves trade roles at a block boundary, and that boundary is set either by a programmable byte length or by an end-of-frame marker on the incoming byte. The processor only ever sees the half it was given. When it has finished with that half, it returns it with a release pulse.

Each handover has three effects:
- a one-cycle interrupt pulse is raised;
- the number of valid bytes is latched for the processor;
- the read pointer restarts at the first byte.

The read port takes single bytes. When a static width select is high, it also takes 16-bit words. For word reads, a lane-order input decides which data lane carries the byte at the even address. A writer that completes its half while the processor still holds the other half is stalled. Bytes that arrive during the stall are dropped, and a sticky overflow flag records the loss.

Top module: `rxb_pingpong`

## Requirements
- R1: After a synchronous active-low reset the outputs read as follows:
  - `cpu_valid` is 0, `cpu_count` is 0, `ovf_flag` is 0, `irq_full` is 0 and `rd_data` is 0.
  - The block length is the full half (32 bytes by default).
  - A byte read while no half is held returns 0.
- R2: A block-length write with code c selects 2^(c+1) bytes for c = 0 to 3. Any code of 4 or above selects the full half of 32 bytes. A half is handed to the processor on the write that makes its byte count reach the selected length.
- R3: On every handover, `irq_full` is high for exactly one cycle. In the same cycle, `cpu_valid` goes to 1 and `cpu_count` shows the number of bytes in the handed half.
- R4: A written byte with `wr_eof` = 1 is stored, and it completes the half early. The count it hands over includes that byte.
- R5: A byte read returns the next byte on `rd_data[7:0]` with `rd_data[15:8]` = 0, and it advances the pointer by one.
  - When `wide_sel` = 0, `rd_word` is ignored and every read is a byte read.
  - Bytes come out in the order they were written.
- R6: A word read (`wide_sel` = 1, `rd_word` = 1) returns bytes n and n+1 and advances the pointer by two.
  - With `lane_mode` = 0, byte n goes on `rd_data[7:0]` and byte n+1 on `rd_data[15:8]`.
  - With `lane_mode` = 1, the order is reversed.
- R7: A read issued when no byte is left returns 0 and leaves the pointer in place. A word read with exactly one byte left puts that byte in the lane of byte n, returns 0 in the other lane, and advances the pointer by one.
- R8: Releasing a half while the writer's half is incomplete drops `cpu_valid` and clears `cpu_count`. A release pulse while `cpu_valid` = 0 has no effect.
- R9: While the writer's half is complete and the processor still holds the other half, each incoming byte is dropped and sets `ovf_flag`. The flag stays set until an `ovf_clr` pulse.
- R10: A release while the writer's half is complete hands that pending half over at once, with the behaviour of R3. The dropped bytes are not in it, and reading restarts at its first byte.
- R11: A reset in the middle of operation discards any partly written half and restores the full-half block length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Incoming byte strobe from the controller |
| wr_data | input | 8 | Incoming byte |
| wr_eof | input | 1 | Incoming byte closes the current frame |
| len_we | input | 1 | Load a new block-length code |
| len_code | input | 4 | Block-length code (see R2) |
| release_cmd | input | 1 | Processor returns its half |
| ovf_clr | input | 1 | Clear the overflow flag |
| wide_sel | input | 1 | Static: 1 = 16-bit read port |
| lane_mode | input | 1 | Static: word lane order (see R6) |
| rd_en | input | 1 | Read strobe |
| rd_word | input | 1 | Word read request (effective only with wide_sel) |
| rd_data | output | 16 | Registered read result |
| cpu_valid | output | 1 | Processor currently holds a half |
| cpu_count | output | 6 | Valid bytes in the processor's half |
| irq_full | output | 1 | One-cycle handover pulse |
| ovf_flag | output | 1 | Sticky dropped-byte flag |

## Verification
The bench builds the block with its default 32-byte halves and 4-bit length code. With these values, the reset length, a full 32-byte block and the clamping of out-of-range codes can all be reached in a few hundred cycles. The shorter codes of 2 and 4 bytes then make it cheap to fill both halves, which exercises the stalled writer, the dropped byte and the pending swap on release. The bench uses both lane orders and both port widths, and it includes odd-length frames, so the partial word read and reads past the end are covered.

// File: rtl/rxb_pkg.sv
// Package: shared byte type and the block-length decode used by the
// ping-pong receive buffer. Assumes half sizes that are powers of two.
package rxb_pkg;
    typedef logic [7:0] byte_t;

    // Map a length code to a byte count: 2^(code+1), clamped to the half.
    function automatic int unsigned len_bytes(input int unsigned code,
                                              input int unsigned ofs_w);
        if (code + 1 >= ofs_w)
            return 1 << ofs_w;
        return 1 << (code + 1);
    endfunction
endpackage

// File: rtl/rxb_store.sv
// Byte storage for both halves: one write port from the controller side,
// two combinational read ports for the processor side (bytes n and n+1).
// Assumes the address MSB selects the half. Content is not reset; the
// byte counts in the control logic decide what is valid.
module rxb_store #(
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    waddr,
    input  rxb_pkg::byte_t       wdata,
    input  logic [ADDR_W-1:0]    raddr0,
    input  logic [ADDR_W-1:0]    raddr1,
    output rxb_pkg::byte_t       rdata0,
    output rxb_pkg::byte_t       rdata1
);
    localparam int DEPTH = 1 << ADDR_W;

    rxb_pkg::byte_t mem [DEPTH];

    // Store an accepted byte from the controller side.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Present the two neighbouring bytes to the read port.
    always_comb begin
        rdata0 = mem[raddr0];
        rdata1 = mem[raddr1];
    end
endmodule

// File: rtl/rxb_ctrl.sv
// Half ownership control: tracks which half the writer fills, when a half
// is handed to the processor, the pending-full stall, byte drops and the
// programmable block length. Assumes release_cmd and ovf_clr are pulses.
module rxb_ctrl #(
    parameter int HALF_BYTES = 32,
    parameter int CODE_W     = 4,
    localparam int OFS_W     = $clog2(HALF_BYTES),
    localparam int CNT_W     = OFS_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic               wr_eof,
    input  logic               len_we,
    input  logic [CODE_W-1:0]  len_code,
    input  logic               release_cmd,
    input  logic               ovf_clr,
    output logic               mem_we,
    output logic [OFS_W:0]     mem_waddr,
    output logic               cpu_own,
    output logic               cpu_bank,
    output logic [CNT_W-1:0]   cpu_count,
    output logic               handover,
    output logic               irq,
    output logic               ovf
);
    logic             wr_bank;
    logic [CNT_W-1:0] wr_cnt;
    logic             wr_full;
    logic [CNT_W-1:0] len_q;

    logic             accept;
    logic [CNT_W-1:0] cnt_next;
    logic             wdone;
    logic             rel;
    logic             hand_new;
    logic             hand_pend;
    logic             set_full;
    logic             free_half;

    // Decode this cycle's write, completion and release events.
    always_comb begin
        accept    = wr_valid && !wr_full;
        cnt_next  = wr_cnt + 1'b1;
        wdone     = accept && ((cnt_next >= len_q) || wr_eof);
        rel       = release_cmd && cpu_own;
        hand_new  = wdone && (!cpu_own || rel);
        hand_pend = rel && wr_full;
        set_full  = wdone && cpu_own && !rel;
        free_half = rel && !wr_full && !wdone;
        handover  = hand_new || hand_pend;
        mem_we    = accept;
        mem_waddr = {wr_bank, wr_cnt[OFS_W-1:0]};
        cpu_bank  = ~wr_bank;
    end

    // Block-length register, reset to the full half.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= CNT_W'(HALF_BYTES);
        else if (len_we)
            len_q <= CNT_W'(rxb_pkg::len_bytes(int'(len_code), OFS_W));
    end

    // Ownership, fill counter and processor byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank   <= 1'b0;
            wr_cnt    <= '0;
            wr_full   <= 1'b0;
            cpu_own   <= 1'b0;
            cpu_count <= '0;
        end else if (hand_new) begin
            wr_bank   <= ~wr_bank;
            wr_cnt    <= '0;
            cpu_own   <= 1'b1;
            cpu_count <= cnt_next;
        end else if (hand_pend) begin
            wr_bank   <= ~wr_bank;
            wr_cnt    <= '0;
            wr_full   <= 1'b0;
            cpu_count <= wr_cnt;
        end else begin
            if (set_full) begin
                wr_full <= 1'b1;
                wr_cnt  <= cnt_next;
            end else if (accept) begin
                wr_cnt  <= cnt_next;
            end
            if (free_half) begin
                cpu_own   <= 1'b0;
                cpu_count <= '0;
            end
        end
    end

    // Handover interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= handover;
    end

    // Sticky overflow: set by a dropped byte, cleared by the processor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (wr_valid && wr_full)
            ovf <= 1'b1;
        else if (ovf_clr)
            ovf <= 1'b0;
    end

    // R3: an interrupt pulse only accompanies a held, non-empty half.
    p_irq_with_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cpu_own && cpu_count != '0));

    // R2: the processor count never exceeds one half.
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_own |-> (cpu_count <= CNT_W'(HALF_BYTES)));

    // R9: the writer can only be stalled while the processor holds a half.
    p_full_needs_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full |-> cpu_own);

    // R9: the overflow flag is sticky until cleared.
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R9: a stalled writer does not move its fill count.
    p_drop_holds_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_full && !release_cmd) |=> $stable(wr_cnt));
endmodule

// File: rtl/rxb_rdport.sv
// Processor read port: walks the held half with a read pointer, forms byte
// or word results, steers bytes onto the 16-bit lanes and returns zero past
// the latched count. Assumes wide_sel and lane_mode are static.
module rxb_rdport #(
    parameter int HALF_BYTES = 32,
    localparam int OFS_W     = $clog2(HALF_BYTES),
    localparam int CNT_W     = OFS_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               rd_word,
    input  logic               wide_sel,
    input  logic               lane_mode,
    input  logic               cpu_own,
    input  logic               cpu_bank,
    input  logic [CNT_W-1:0]   cpu_count,
    input  logic               handover,
    output logic [OFS_W:0]     raddr0,
    output logic [OFS_W:0]     raddr1,
    input  rxb_pkg::byte_t     byte0,
    input  rxb_pkg::byte_t     byte1,
    output logic [15:0]        rd_data
);
    logic [CNT_W-1:0] rd_ptr;
    logic [CNT_W-1:0] avail;
    logic             word_rd;
    rxb_pkg::byte_t   second;
    logic [15:0]      result;
    logic [CNT_W-1:0] step;

    // Form addresses, remaining bytes and the lane-steered result.
    always_comb begin
        raddr0  = {cpu_bank, rd_ptr[OFS_W-1:0]};
        raddr1  = {cpu_bank, rd_ptr[OFS_W-1:0] + 1'b1};
        avail   = cpu_own ? (cpu_count - rd_ptr) : '0;
        word_rd = wide_sel && rd_word;
        second  = (avail > CNT_W'(1)) ? byte1 : 8'h00;
        if (avail == '0) begin
            result = 16'h0000;
            step   = '0;
        end else if (!word_rd) begin
            result = {8'h00, byte0};
            step   = CNT_W'(1);
        end else begin
            result = lane_mode ? {byte0, second} : {second, byte0};
            step   = (avail > CNT_W'(1)) ? CNT_W'(2) : CNT_W'(1);
        end
    end

    // Read pointer: restarts on handover, advances on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr <= '0;
        else if (handover)
            rd_ptr <= '0;
        else if (rd_en)
            rd_ptr <= rd_ptr + step;
    end

    // Registered read result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= 16'h0000;
        else if (rd_en)
            rd_data <= result;
    end

    // R7: reading with nothing left yields zero.
    p_past_end_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && avail == '0) |=> (rd_data == 16'h0000));

    // R7: the pointer never runs beyond the latched count.
    p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_own |-> (rd_ptr <= cpu_count));

    // R5: a byte read never drives the upper lane.
    p_byte_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(wide_sel && rd_word)) |=> (rd_data[15:8] == 8'h00));
endmodule

// File: rtl/rxb_pingpong.sv
// Top level of the ping-pong receive buffer: joins storage, half ownership
// control and the processor read port. Assumes a single clock domain and a
// synchronous active-low reset shared by writer and reader.
module rxb_pingpong #(
    parameter int HALF_BYTES = 32,
    parameter int CODE_W     = 4,
    localparam int OFS_W     = $clog2(HALF_BYTES),
    localparam int CNT_W     = OFS_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [7:0]         wr_data,
    input  logic               wr_eof,
    input  logic               len_we,
    input  logic [CODE_W-1:0]  len_code,
    input  logic               release_cmd,
    input  logic               ovf_clr,
    input  logic               wide_sel,
    input  logic               lane_mode,
    input  logic               rd_en,
    input  logic               rd_word,
    output logic [15:0]        rd_data,
    output logic               cpu_valid,
    output logic [CNT_W-1:0]   cpu_count,
    output logic               irq_full,
    output logic               ovf_flag
);
    logic             mem_we;
    logic [OFS_W:0]   mem_waddr;
    logic [OFS_W:0]   raddr0;
    logic [OFS_W:0]   raddr1;
    rxb_pkg::byte_t   byte0;
    rxb_pkg::byte_t   byte1;
    logic             cpu_bank;
    logic             handover;

    rxb_store #(.ADDR_W(OFS_W + 1)) u_store (
        .clk    (clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (wr_data),
        .raddr0 (raddr0),
        .raddr1 (raddr1),
        .rdata0 (byte0),
        .rdata1 (byte1)
    );

    rxb_ctrl #(.HALF_BYTES(HALF_BYTES), .CODE_W(CODE_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_eof      (wr_eof),
        .len_we      (len_we),
        .len_code    (len_code),
        .release_cmd (release_cmd),
        .ovf_clr     (ovf_clr),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .cpu_own     (cpu_valid),
        .cpu_bank    (cpu_bank),
        .cpu_count   (cpu_count),
        .handover    (handover),
        .irq         (irq_full),
        .ovf         (ovf_flag)
    );

    rxb_rdport #(.HALF_BYTES(HALF_BYTES)) u_rdport (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_word   (rd_word),
        .wide_sel  (wide_sel),
        .lane_mode (lane_mode),
        .cpu_own   (cpu_valid),
        .cpu_bank  (cpu_bank),
        .cpu_count (cpu_count),
        .handover  (handover),
        .raddr0    (raddr0),
        .raddr1    (raddr1),
        .byte0     (byte0),
        .byte1     (byte1),
        .rd_data   (rd_data)
    );
endmodule

// File: tb/tb_rxb_pingpong.sv
// Directed bench for the ping-pong receive buffer: one task per scenario.
module tb_rxb_pingpong;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_eof = 1'b0;
    logic        len_we = 1'b0;
    logic [3:0]  len_code = 4'd0;
    logic        release_cmd = 1'b0;
    logic        ovf_clr = 1'b0;
    logic        wide_sel = 1'b0;
    logic        lane_mode = 1'b0;
    logic        rd_en = 1'b0;
    logic        rd_word = 1'b0;
    logic [15:0] rd_data;
    logic        cpu_valid;
    logic [5:0]  cpu_count;
    logic        irq_full;
    logic        ovf_flag;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    rxb_pingpong dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_eof(wr_eof), .len_we(len_we), .len_code(len_code),
        .release_cmd(release_cmd), .ovf_clr(ovf_clr), .wide_sel(wide_sel),
        .lane_mode(lane_mode), .rd_en(rd_en), .rd_word(rd_word),
        .rd_data(rd_data), .cpu_valid(cpu_valid), .cpu_count(cpu_count),
        .irq_full(irq_full), .ovf_flag(ovf_flag)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog act=%0d exp=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic eof);
        wr_valid = 1'b1; wr_data = d; wr_eof = eof;
        @(negedge clk);
        wr_valid = 1'b0; wr_eof = 1'b0;
    endtask

    task automatic rd(input logic word);
        rd_en = 1'b1; rd_word = word;
        @(negedge clk);
        rd_en = 1'b0; rd_word = 1'b0;
    endtask

    task automatic rel();
        release_cmd = 1'b1;
        @(negedge clk);
        release_cmd = 1'b0;
    endtask

    task automatic set_len(input logic [3:0] c);
        len_we = 1'b1; len_code = c;
        @(negedge clk);
        len_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 cpu_valid", {15'd0, cpu_valid}, 16'd0);
        chk("R1 cpu_count", {10'd0, cpu_count}, 16'd0);
        chk("R1 ovf_flag", {15'd0, ovf_flag}, 16'd0);
        chk("R1 irq_full", {15'd0, irq_full}, 16'd0);
        chk("R1 rd_data", rd_data, 16'd0);
        rd(1'b0);
        chk("R1 read with no half", rd_data, 16'd0);
    endtask

    task automatic t_default_len();
        for (int i = 0; i < 31; i++) push(8'h10 + 8'(i), 1'b0);
        chk("R2 31 bytes not handed", {15'd0, cpu_valid}, 16'd0);
        push(8'h2F, 1'b0);
        chk("R3 valid after 32", {15'd0, cpu_valid}, 16'd1);
        chk("R3 irq pulse", {15'd0, irq_full}, 16'd1);
        chk("R3 count 32", {10'd0, cpu_count}, 16'd32);
        idle();
        chk("R3 irq one cycle", {15'd0, irq_full}, 16'd0);
    endtask

    task automatic t_reads();
        wide_sel = 1'b0;
        rd(1'b1);
        chk("R5 byte 0 narrow port", rd_data, 16'h0010);
        rd(1'b1);
        chk("R5 byte 1 narrow port", rd_data, 16'h0011);
        wide_sel = 1'b1;
        rd(1'b0);
        chk("R5 byte read on wide port", rd_data, 16'h0012);
        lane_mode = 1'b0;
        rd(1'b1);
        chk("R6 word lane_mode 0", rd_data, 16'h1413);
        lane_mode = 1'b1;
        rd(1'b1);
        chk("R6 word lane_mode 1", rd_data, 16'h1516);
        rel();
        chk("R8 release frees", {15'd0, cpu_valid}, 16'd0);
        chk("R8 release clears count", {10'd0, cpu_count}, 16'd0);
        rel();
        chk("R8 idle release ignored", {15'd0, cpu_valid}, 16'd0);
        chk("R8 idle release no ovf", {15'd0, ovf_flag}, 16'd0);
    endtask

    task automatic t_len_eof();
        lane_mode = 1'b0;
        set_len(4'd1);
        for (int i = 0; i < 3; i++) push(8'h20 + 8'(i), 1'b0);
        chk("R2 code1 3 bytes held", {15'd0, cpu_valid}, 16'd0);
        push(8'h23, 1'b0);
        chk("R2 code1 handover", {15'd0, cpu_valid}, 16'd1);
        chk("R2 code1 count", {10'd0, cpu_count}, 16'd4);
        rd(1'b1);
        chk("R6 word first pair", rd_data, 16'h2120);
        rd(1'b1);
        chk("R6 word second pair", rd_data, 16'h2322);
        rd(1'b1);
        chk("R7 word past end", rd_data, 16'h0000);
        rel();
        push(8'h30, 1'b0);
        push(8'h31, 1'b1);
        chk("R4 eof handover", {15'd0, cpu_valid}, 16'd1);
        chk("R4 eof count", {10'd0, cpu_count}, 16'd2);
        chk("R4 eof irq", {15'd0, irq_full}, 16'd1);
        rd(1'b0);
        chk("R4 eof first byte", rd_data, 16'h0030);
        rel();
        push(8'h40, 1'b0);
        push(8'h41, 1'b0);
        push(8'h42, 1'b1);
        chk("R4 odd frame count", {10'd0, cpu_count}, 16'd3);
        rd(1'b1);
        chk("R6 odd frame word", rd_data, 16'h4140);
        lane_mode = 1'b1;
        rd(1'b1);
        chk("R7 partial word", rd_data, 16'h4200);
        rd(1'b0);
        chk("R7 byte past end", rd_data, 16'h0000);
        rel();
    endtask

    task automatic t_overflow();
        lane_mode = 1'b0;
        for (int i = 0; i < 4; i++) push(8'h50 + 8'(i), 1'b0);
        chk("R3 first half held", {15'd0, cpu_valid}, 16'd1);
        for (int i = 0; i < 4; i++) push(8'h60 + 8'(i), 1'b0);
        chk("R9 no ovf yet", {15'd0, ovf_flag}, 16'd0);
        push(8'h64, 1'b0);
        chk("R9 drop sets ovf", {15'd0, ovf_flag}, 16'd1);
        rel();
        chk("R10 swap keeps valid", {15'd0, cpu_valid}, 16'd1);
        chk("R10 swap irq", {15'd0, irq_full}, 16'd1);
        chk("R10 swap count", {10'd0, cpu_count}, 16'd4);
        rd(1'b0);
        chk("R10 pointer restart", rd_data, 16'h0060);
        chk("R9 ovf sticky", {15'd0, ovf_flag}, 16'd1);
        ovf_clr = 1'b1;
        idle();
        ovf_clr = 1'b0;
        chk("R9 ovf cleared", {15'd0, ovf_flag}, 16'd0);
        rd(1'b1);
        chk("R10 pending data order", rd_data, 16'h6261);
        rd(1'b0);
        chk("R10 dropped byte absent", rd_data, 16'h0063);
        rd(1'b0);
        chk("R10 end of pending half", rd_data, 16'h0000);
        rel();
        chk("R8 free after swap", {15'd0, cpu_valid}, 16'd0);
    endtask

    task automatic t_clamp();
        set_len(4'd7);
        for (int i = 0; i < 31; i++) push(8'h70 + 8'(i), 1'b0);
        chk("R2 clamp 31 held", {15'd0, cpu_valid}, 16'd0);
        push(8'hAA, 1'b0);
        chk("R2 clamp count", {10'd0, cpu_count}, 16'd32);
        rel();
    endtask

    task automatic t_midreset();
        set_len(4'd0);
        push(8'h01, 1'b0);
        push(8'h02, 1'b0);
        chk("R2 code0 count", {10'd0, cpu_count}, 16'd2);
        rel();
        push(8'h03, 1'b0);
        do_reset();
        push(8'h04, 1'b0);
        push(8'h05, 1'b0);
        chk("R11 length restored", {15'd0, cpu_valid}, 16'd0);
        chk("R11 count empty", {10'd0, cpu_count}, 16'd0);
        rd(1'b0);
        chk("R11 nothing readable", rd_data, 16'h0000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_default_len();
        t_reads();
        t_len_eof();
        t_overflow();
        t_clamp();
        t_midreset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule